// File: doc/BRIEF.md
# Sixteen-bit Execute Unit with Barrel Shifter

This block is the purely combinational arithmetic and logic stage of a small register-based processor with a 16-bit data path. It takes two operands, an immediate value with a select that replaces the second operand, a four-bit shift amount and a four-bit operation code. In the same cycle it returns a result word, a zero flag and a negative flag. The processor's branch logic reads those flags.

The operations are add, subtract, negate, increment and five bitwise operations: AND, OR, XOR, NAND and NOR. There is also a multiply of the low bytes and an unsigned divide that yields quotient and remainder at once. A logarithmic barrel shifter provides logical left, logical right, arithmetic right and left rotation. Branch compares use the subtract operation. A less-than branch is taken when the negative flag is set, and an equal branch is taken when the zero flag is set.

Top module: `alu16_exec`

## Requirements
- R1: When `use_imm` is 1, `imm_val` replaces `opnd_b` as the second operand for every operation that reads a second operand: codes 0, 1, 4 to 10 and 15.
- R2: Codes 0 (ADD, a+b), 1 (SUB, a-b), 2 (NEG, 0-a) and 3 (INC, a+1) produce results modulo 2^16. For example, INC of 0xFFFF gives 0x0000.
- R3: Codes 4 to 8 give AND, OR, XOR, NAND and NOR of the two operands, in that order.
- R4: Code 9 (MUL) gives the full 16-bit unsigned product of bits [7:0] of each operand.
- R5: `quotient` and `remainder` always show the unsigned division of `opnd_a` by the second operand, whatever the operation code. Code 10 (DIV) also places the quotient on `result`.
- R6: When the divisor is zero, `quotient` is 0xFFFF and `remainder` equals `opnd_a`.
- R7: Codes 11 (SLL), 12 (SRL) and 13 (SRA) shift `opnd_a` by `shamt` (0 to 15). SRA fills with bit 15 of `opnd_a`. A shift amount of 0 returns `opnd_a` unchanged.
- R8: Code 14 (ROL) rotates `opnd_a` left by `shamt`. Bits leaving bit 15 re-enter at bit 0.
- R9: Code 15 (MOVE) returns the second operand unchanged.
- R10: `zero_flag` is 1 exactly when `result` is 0, and `neg_flag` equals bit 15 of `result`, for every operation. Under SUB these flags give the equal and less-than branch conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand, dividend and shift source |
| opnd_b | input | 16 | Second operand from the register path |
| imm_val | input | 16 | Immediate second operand |
| use_imm | input | 1 | 1 selects `imm_val` as the second operand |
| shamt | input | 4 | Shift or rotate amount |
| op_sel | input | 4 | Operation code (see R2 to R9) |
| result | output | 16 | Result of the selected operation |
| quotient | output | 16 | Unsigned quotient of `opnd_a` by the second operand |
| remainder | output | 16 | Unsigned remainder of the same division |
| zero_flag | output | 1 | Result is zero |
| neg_flag | output | 1 | Bit 15 of the result |

## Verification
The bench builds the block with its default width of 16, so `shamt` is 4 bits and the multiply takes 8-bit halves. At that width every shift amount from 0 to 15 can be reached, including the largest rotation and a full-length arithmetic fill. The byte product 0xFF times 0xFF can also be reached. On the divide side, the bench covers a divide by zero, a divisor larger than the dividend, and the subtract wrap that decides the less-than branch. Directed corner vectors are applied first, followed by a long run of pseudo-random vectors on all sixteen operation codes with both operand sources.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_NEG  = 4'd2,
        OP_INC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NAND = 4'd7,
        OP_NOR  = 4'd8,
        OP_MUL  = 4'd9,
        OP_DIV  = 4'd10,
        OP_SLL  = 4'd11,
        OP_SRL  = 4'd12,
        OP_SRA  = 4'd13,
        OP_ROL  = 4'd14,
        OP_MOVE = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        LK_AND  = 3'd0,
        LK_OR   = 3'd1,
        LK_XOR  = 3'd2,
        LK_NAND = 3'd3,
        LK_NOR  = 3'd4
    } logic_kind_e;

    typedef enum logic [1:0] {
        SM_SLL = 2'd0,
        SM_SRL = 2'd1,
        SM_SRA = 2'd2,
        SM_ROL = 2'd3
    } shift_mode_e;

endpackage

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic_kind_e       kind,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        unique case (kind)
            LK_AND:  dout = lhs & rhs;
            LK_OR:   dout = lhs | rhs;
            LK_XOR:  dout = lhs ^ rhs;
            LK_NAND: dout = ~(lhs & rhs);
            LK_NOR:  dout = ~(lhs | rhs);
            default: dout = '0;
        endcase
    end

    // R3: NOR never sets a bit that either operand holds
    always_comb begin
        if (kind == LK_NOR) begin
            assert_nor_disjoint_R3: assert ((dout & (lhs | rhs)) == '0)
                else $error("NOR output overlaps operand bits");
        end
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amount,
    input  shift_mode_e       mode,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stg [0:SH_W];

    assign stg[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [DATA_W-1:0] moved;
        always_comb begin
            unique case (mode)
                SM_SLL: moved = stg[s] << K;
                SM_SRL: moved = stg[s] >> K;
                SM_SRA: moved = $signed(stg[s]) >>> K;
                SM_ROL: moved = (stg[s] << K) | (stg[s] >> (DATA_W - K));
            endcase
        end
        assign stg[s+1] = amount[s] ? moved : stg[s];
    end

    assign dout = stg[SH_W];

    always_comb begin
        if (mode == SM_ROL) begin
            assert_rol_keeps_ones_R8: assert ($countones(dout) == $countones(din))
                else $error("rotation changed the number of set bits");
        end
        if (mode == SM_SRA) begin
            assert_sra_sign_R7: assert (dout[DATA_W-1] == din[DATA_W-1])
                else $error("arithmetic shift lost the sign");
        end
        if (mode == SM_SRL && amount != '0) begin
            assert_srl_fill_R7: assert (dout[DATA_W-1] == 1'b0)
                else $error("logical right shift filled with one");
        end
    end

endmodule

// File: rtl/alu16_div.sv
module alu16_div #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] quot,
    output logic [DATA_W-1:0] rem
);

    logic [DATA_W-1:0] part [0:DATA_W];

    assign part[0] = '0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        logic [DATA_W:0] shifted;
        logic [DATA_W:0] diff;
        logic            fits;
        assign shifted = {part[i], dividend[DATA_W-1-i]};
        assign diff    = shifted - {1'b0, divisor};
        assign fits    = ~diff[DATA_W];
        assign quot[DATA_W-1-i] = fits;
        assign part[i+1] = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    end

    assign rem = part[DATA_W];

    always_comb begin
        if (divisor == '0) begin
            assert_divzero_R6: assert (quot == '1 && rem == dividend)
                else $error("divide by zero gave wrong pair");
        end else begin
            assert_div_identity_R5: assert (
                ({{DATA_W{1'b0}}, quot} * {{DATA_W{1'b0}}, divisor}
                 + {{DATA_W{1'b0}}, rem}) == {{DATA_W{1'b0}}, dividend}
                && rem < divisor)
                else $error("quotient and remainder do not rebuild the dividend");
        end
    end

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
    import alu16_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              use_imm,
    input  logic [SH_W-1:0]   shamt,
    input  logic [3:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder,
    output logic              zero_flag,
    output logic              neg_flag
);

    localparam int HALF_W  = DATA_W / 2;
    localparam int MUL_MAX = ((1 << HALF_W) - 1) * ((1 << HALF_W) - 1);

    alu_op_e           op;
    logic [DATA_W-1:0] src_b;
    logic [DATA_W-1:0] sum_res;
    logic [DATA_W-1:0] diff_res;
    logic [DATA_W-1:0] neg_res;
    logic [DATA_W-1:0] inc_res;
    logic [DATA_W-1:0] mul_res;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] shift_res;
    logic_kind_e       lkind;
    shift_mode_e       smode;

    assign op    = alu_op_e'(op_sel);
    assign src_b = use_imm ? imm_val : opnd_b;

    assign sum_res  = opnd_a + src_b;
    assign diff_res = opnd_a - src_b;
    assign neg_res  = '0 - opnd_a;
    assign inc_res  = opnd_a + 1'b1;
    assign mul_res  = {{HALF_W{1'b0}}, opnd_a[HALF_W-1:0]}
                    * {{HALF_W{1'b0}}, src_b[HALF_W-1:0]};

    always_comb begin
        unique case (op)
            OP_OR:   lkind = LK_OR;
            OP_XOR:  lkind = LK_XOR;
            OP_NAND: lkind = LK_NAND;
            OP_NOR:  lkind = LK_NOR;
            default: lkind = LK_AND;
        endcase
        unique case (op)
            OP_SRL:  smode = SM_SRL;
            OP_SRA:  smode = SM_SRA;
            OP_ROL:  smode = SM_ROL;
            default: smode = SM_SLL;
        endcase
    end

    alu16_logic #(.DATA_W(DATA_W)) u_logic (
        .lhs  (opnd_a),
        .rhs  (src_b),
        .kind (lkind),
        .dout (logic_res)
    );

    alu16_shift #(.DATA_W(DATA_W)) u_shift (
        .din    (opnd_a),
        .amount (shamt),
        .mode   (smode),
        .dout   (shift_res)
    );

    alu16_div #(.DATA_W(DATA_W)) u_div (
        .dividend (opnd_a),
        .divisor  (src_b),
        .quot     (quotient),
        .rem      (remainder)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  result = sum_res;
            OP_SUB:  result = diff_res;
            OP_NEG:  result = neg_res;
            OP_INC:  result = inc_res;
            OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR: result = logic_res;
            OP_MUL:  result = mul_res;
            OP_DIV:  result = quotient;
            OP_SLL, OP_SRL, OP_SRA, OP_ROL: result = shift_res;
            OP_MOVE: result = src_b;
        endcase
    end

    assign zero_flag = (result == '0);
    assign neg_flag  = result[DATA_W-1];

    always_comb begin
        if (op == OP_SUB && zero_flag) begin
            assert_equal_branch_R10: assert (opnd_a == src_b)
                else $error("zero difference from unequal operands");
        end
        if (op == OP_MUL) begin
            assert_mul_bound_R4: assert (int'(result) <= MUL_MAX)
                else $error("byte product exceeds its range");
        end
        if (op == OP_NAND) begin
            assert_nand_clear_R3: assert ((result & opnd_a & src_b) == '0)
                else $error("NAND kept a bit set in both operands");
        end
        if (op == OP_INC && opnd_a == '1) begin
            assert_inc_wrap_R2: assert (zero_flag)
                else $error("increment did not wrap to zero");
        end
    end

endmodule

// File: tb/tb_alu16_exec.sv
module tb_alu16_exec;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, imm_val = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  shamt = '0, op_sel = '0;
    logic [15:0] result, quotient, remainder;
    logic        zero_flag, neg_flag;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_exec dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val), .use_imm(use_imm),
        .shamt(shamt), .op_sel(op_sel), .result(result), .quotient(quotient),
        .remainder(remainder), .zero_flag(zero_flag), .neg_flag(neg_flag)
    );

    function automatic void model(input int op, input int a, input int b,
                                  output int res, output int q, output int r);
        int sh = int'(shamt);
        q = (b == 0) ? 'hFFFF : a / b;
        r = (b == 0) ? a : a % b;
        case (op)
            0:  res = a + b;
            1:  res = a - b;
            2:  res = -a;
            3:  res = a + 1;
            4:  res = a & b;
            5:  res = a | b;
            6:  res = a ^ b;
            7:  res = ~(a & b);
            8:  res = ~(a | b);
            9:  res = (a % 256) * (b % 256);
            10: res = q;
            11: res = a << sh;
            12: res = a >> sh;
            13: res = (a >= 'h8000) ? ((a | 'hFFFF0000) >>> sh) : (a >> sh);
            14: res = (a << sh) | (a >> (16 - sh));
            default: res = b;
        endcase
        res = res & 'hFFFF;
    endfunction

    function automatic string res_tag(input int op, input bit imm);
        if (imm && (op <= 1 || (op >= 4 && op <= 10) || op == 15)) return "R1";
        case (op)
            0, 1, 2, 3:    return "R2";
            4, 5, 6, 7, 8: return "R3";
            9:             return "R4";
            10:            return "R5";
            11, 12, 13:    return "R7";
            14:            return "R8";
            default:       return "R9";
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h (op=%0d a=%h b=%h imm=%h sel=%0b sh=%0d)",
                     tag, what, act, exp, op_sel, opnd_a, opnd_b, imm_val, use_imm, shamt);
        end
    endtask

    task automatic apply(input int op, input int a, input int b, input int imm,
                         input bit sel, input int sh);
        int er, eq, erm, bsrc;
        @(posedge clk);
        #1;
        op_sel = 4'(op); opnd_a = 16'(a); opnd_b = 16'(b);
        imm_val = 16'(imm); use_imm = sel; shamt = 4'(sh);
        @(negedge clk);
        bsrc = sel ? (imm & 'hFFFF) : (b & 'hFFFF);
        model(op, a & 'hFFFF, bsrc, er, eq, erm);
        vectors++;
        cmp(res_tag(op, sel), "result", int'(result), er);
        cmp((bsrc == 0) ? "R6" : "R5", "quotient", int'(quotient), eq);
        cmp((bsrc == 0) ? "R6" : "R5", "remainder", int'(remainder), erm);
        cmp("R10", "zero_flag", int'(zero_flag), (er == 0) ? 1 : 0);
        cmp("R10", "neg_flag", int'(neg_flag), (er >= 'h8000) ? 1 : 0);
    endtask

    initial begin
        // idle inputs: ADD of zeros, result zero with zero flag (R2, R10)
        apply(0, 0, 0, 0, 0, 0);
        apply(0, 'hFFFF, 1, 0, 0, 0);          // R2 add wrap
        apply(3, 'hFFFF, 0, 0, 0, 0);          // R2 increment wrap
        apply(2, 'h8000, 0, 0, 0, 0);          // R2 negate most negative
        apply(2, 1, 0, 0, 0, 0);               // R2 negate one
        apply(1, 5, 5, 0, 0, 0);               // R10 equal branch
        apply(1, 3, 7, 0, 0, 0);               // R10 less-than branch
        apply(1, 9, 0, 4, 1, 0);               // R1 subtract immediate
        apply(4, 'hF0F0, 'hFF00, 0, 0, 0);     // R3 AND
        apply(7, 'hF0F0, 'hFF00, 0, 0, 0);     // R3 NAND
        apply(8, 'hF0F0, 0, 'h0F00, 1, 0);     // R3 NOR with immediate, R1
        apply(6, 'hAAAA, 'h5555, 0, 0, 0);     // R3 XOR
        apply(9, 'h12FF, 'h34FF, 0, 0, 0);     // R4 largest byte product
        apply(9, 'h0003, 'hFF00, 7, 1, 0);     // R4 high bytes ignored, R1
        apply(10, 100, 7, 0, 0, 0);            // R5
        apply(10, 3, 'hFFFF, 0, 0, 0);         // R5 divisor larger
        apply(10, 'h1234, 0, 0, 0, 0);         // R6 divide by zero
        apply(0, 'h4321, 9, 0, 1, 0);          // R6 on quotient ports, R1 zero imm
        apply(11, 'h0001, 0, 0, 0, 15);        // R7 SLL max
        apply(12, 'h8000, 0, 0, 0, 15);        // R7 SRL max
        apply(13, 'h8000, 0, 0, 0, 15);        // R7 SRA fill
        apply(13, 'h7FFF, 0, 0, 0, 3);         // R7 SRA positive
        apply(11, 'hBEEF, 0, 0, 0, 0);         // R7 zero amount
        apply(14, 'h8001, 0, 0, 0, 1);         // R8 wrap one bit
        apply(14, 'h1234, 0, 0, 0, 15);        // R8 max rotate
        apply(15, 'h1111, 'h2222, 'h3333, 1, 0); // R9 move immediate
        apply(15, 'h1111, 'h2222, 'h3333, 0, 0); // R9 move register
        for (int i = 0; i < N_RANDOM; i++) begin
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 'hFFFF)),
                  (i % 13 == 0) ? 0 : int'($urandom_range(0, 'hFFFF)),
                  int'($urandom_range(0, 'hFFFF)), 1'($urandom_range(0, 1)),
                  int'($urandom_range(0, 15)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule